// File: doc/BRIEF.md
# DMA Control and Interrupt Register Block

This block is the software-visible control face of a multichannel DMA engine that moves data in a transmit and a receive direction. A 32-bit register bus carries address, write enable and write data, and read data returns combinationally for the address presented. Through this bus, software switches each direction on or off and asks for a channel to be torn down. It can also start a self-clearing soft reset that lasts a fixed number of cycles.

The channel logic reports work with one-cycle event pulses, one bit per channel in each direction, plus a host-error pulse. Each event latches a raw status bit. The bit clears when the channel logic signals that software has acknowledged that channel's completion pointer. Three interrupt groups (transmit, receive and DMA-level) each keep a mask. The mask is changed only through a write-one-to-set address and a write-one-to-clear address, and both addresses read back the current mask. Raw status and masked status (raw AND mask) are readable side by side.

A single interrupt line is driven by a small controller with three named states. In ST_RUN it raises the line as soon as any masked bit is set and then holds it. An end-of-interrupt write moves it to ST_EOI_GAP, where the line is low for exactly one cycle and is then re-sampled, before it returns to ST_RUN. A soft reset write moves it from ST_RUN or ST_EOI_GAP to ST_RESET. It stays in ST_RESET for RESET_CYCLES cycles and then goes to ST_RUN.

Top module: `chdma_csr_top`

## Requirements
- R1: After rst_n is released, every register address reads 0, and irq, tx_enable, rx_enable, td_tx_req and td_rx_req are 0.
- R2: Bit 0 of a write to 0x04 (transmit) or 0x14 (receive) sets that direction's enable, with 1 meaning on. The register reads back the bit in bit 0 and drives tx_enable or rx_enable from the next cycle.
- R3: A write to 0x08 (transmit) or 0x18 (receive) raises td_tx_req or td_rx_req for exactly one cycle, starting the cycle after the write. td_chan carries the write data's low channel-number bits.
- R4: An event pulse on bit i of tx_done_evt or rx_done_evt sets bit i of raw status at 0x80 or 0xA0. A host_err_evt pulse sets bit 1 of the DMA-level raw status at 0xB0.
- R5: A pulse on bit i of tx_cp_ack or rx_cp_ack clears raw bit i. When an event and an acknowledge for the same bit arrive in the same cycle, the bit ends set.
- R6: Writing ones to 0x88, 0xA8 or 0xB8 sets those mask bits. Writing ones to 0x8C, 0xAC or 0xBC clears them, and zero bits change nothing. Either address of a group reads back the current mask. In the DMA-level mask only bit 1 can be set.
- R7: 0x84, 0xA4 and 0xB4 read raw status ANDed with the group's mask.
- R8: irq rises one cycle after any masked bit becomes set. Once high, it stays high until an end-of-interrupt write or a soft reset, even if masked status returns to zero.
- R9: A write to 0x94 (end of interrupt) drives irq low for exactly one cycle. irq then re-asserts if any masked bit is still set, and stays low otherwise.
- R10: Writing 1 in bit 0 to 0x1C makes that address read 1 for RESET_CYCLES cycles and then 0. The reset clears all masks, raw status, enables and irq. Events and register writes that arrive during the reset are ignored, and writing 0 to 0x1C has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_done_evt | input | NUM_CH | Transmit channel event pulses |
| rx_done_evt | input | NUM_CH | Receive channel event pulses |
| host_err_evt | input | 1 | Host error event pulse |
| tx_cp_ack | input | NUM_CH | Transmit completion-pointer acknowledge pulses |
| rx_cp_ack | input | NUM_CH | Receive completion-pointer acknowledge pulses |
| tx_enable | output | 1 | Transmit direction enabled |
| rx_enable | output | 1 | Receive direction enabled |
| td_tx_req | output | 1 | Transmit teardown request pulse |
| td_rx_req | output | 1 | Receive teardown request pulse |
| td_chan | output | CHW | Channel to tear down |
| irq | output | 1 | Interrupt line |

## Verification
The bound checker watches several rules on every cycle. A rising irq must be caused by masked status. irq must stay high until an end-of-interrupt or soft-reset write, and it must fall after every end-of-interrupt write. Transmit events must land in raw status, a teardown write must produce its request, and masks, enables and irq must stay clear for the whole soft reset. Other behaviour can only be shown by the bench's scenarios: the exact soft-reset length, mask readback through both addresses, the event-versus-acknowledge priority, the one-cycle gap and re-assertion after end of interrupt, and writes or events being ignored while reset runs.

// File: rtl/chdma_pkg.sv
package chdma_pkg;
    localparam logic [7:0] OFS_TX_CTL   = 8'h04;
    localparam logic [7:0] OFS_TX_TD    = 8'h08;
    localparam logic [7:0] OFS_RX_CTL   = 8'h14;
    localparam logic [7:0] OFS_RX_TD    = 8'h18;
    localparam logic [7:0] OFS_SRST     = 8'h1C;
    localparam logic [7:0] OFS_TX_RAW   = 8'h80;
    localparam logic [7:0] OFS_TX_MSKD  = 8'h84;
    localparam logic [7:0] OFS_TX_MSET  = 8'h88;
    localparam logic [7:0] OFS_TX_MCLR  = 8'h8C;
    localparam logic [7:0] OFS_EOI      = 8'h94;
    localparam logic [7:0] OFS_RX_RAW   = 8'hA0;
    localparam logic [7:0] OFS_RX_MSKD  = 8'hA4;
    localparam logic [7:0] OFS_RX_MSET  = 8'hA8;
    localparam logic [7:0] OFS_RX_MCLR  = 8'hAC;
    localparam logic [7:0] OFS_DMA_RAW  = 8'hB0;
    localparam logic [7:0] OFS_DMA_MSKD = 8'hB4;
    localparam logic [7:0] OFS_DMA_MSET = 8'hB8;
    localparam logic [7:0] OFS_DMA_MCLR = 8'hBC;

    localparam int DMA_GRP_W = 2;
    localparam logic [DMA_GRP_W-1:0] DMA_WR_MASK = 2'b10;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_EOI_GAP = 2'd1,
        ST_RESET   = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/chdma_irq_grp.sv
module chdma_irq_grp #(
    parameter int W = 8,
    parameter logic [W-1:0] WR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set_evt,
    input  logic [W-1:0] ack,
    input  logic         mset_we,
    input  logic         mclr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked
);
    logic [W-1:0] wbits;
    assign wbits = wdata & WR_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else if (clr) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~ack) | set_evt;
            if (mset_we)
                mask <= mask | wbits;
            else if (mclr_we)
                mask <= mask & ~wbits;
        end
    end

    assign masked = raw & mask;
endmodule

// File: rtl/chdma_ctl_fsm.sv
module chdma_ctl_fsm
    import chdma_pkg::*;
#(
    parameter int RESET_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_req,
    input  logic eoi_req,
    input  logic any_masked,
    output logic busy,
    output logic irq
);
    localparam int CW = $clog2(RESET_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(RESET_CYCLES - 1);

    ctl_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          irq_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sr_req)       state_d = ST_RESET;
                else if (eoi_req) state_d = ST_EOI_GAP;
            end
            ST_EOI_GAP: begin
                if (sr_req) state_d = ST_RESET;
                else        state_d = ST_RUN;
            end
            ST_RESET: begin
                if (cnt_q == '0) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_RESET && sr_req)
                cnt_q <= CNT_LOAD;
            else if (state_q == ST_RESET && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (sr_req || eoi_req) irq_q <= 1'b0;
                    else if (any_masked)   irq_q <= 1'b1;
                end
                ST_EOI_GAP: irq_q <= sr_req ? 1'b0 : any_masked;
                ST_RESET:   irq_q <= 1'b0;
                default:    irq_q <= 1'b0;
            endcase
        end
    end

    assign busy = (state_q == ST_RESET);
    assign irq  = irq_q;
endmodule

// File: rtl/chdma_csr_top.sv
module chdma_csr_top
    import chdma_pkg::*;
#(
    parameter int NUM_CH       = 8,
    parameter int AW           = 8,
    parameter int RESET_CYCLES = 8,
    localparam int CHW         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] tx_done_evt,
    input  logic [NUM_CH-1:0] rx_done_evt,
    input  logic              host_err_evt,
    input  logic [NUM_CH-1:0] tx_cp_ack,
    input  logic [NUM_CH-1:0] rx_cp_ack,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic              td_tx_req,
    output logic              td_rx_req,
    output logic [CHW-1:0]    td_chan,
    output logic              irq
);
    logic sr_busy, wr_ok, sr_we, eoi_we, clr, any_masked;
    logic [NUM_CH-1:0]    tx_raw, tx_mask, tx_masked;
    logic [NUM_CH-1:0]    rx_raw, rx_mask, rx_masked;
    logic [DMA_GRP_W-1:0] dma_raw, dma_mask, dma_masked;

    function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
        return a == AW'(ofs);
    endfunction

    assign wr_ok  = bus_we && !sr_busy;
    assign sr_we  = wr_ok && hit(bus_addr, OFS_SRST) && bus_wdata[0];
    assign eoi_we = wr_ok && hit(bus_addr, OFS_EOI);
    assign clr    = sr_we || sr_busy;

    chdma_irq_grp #(.W(NUM_CH)) u_tx_grp (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .set_evt(tx_done_evt), .ack(tx_cp_ack),
        .mset_we(wr_ok && hit(bus_addr, OFS_TX_MSET)),
        .mclr_we(wr_ok && hit(bus_addr, OFS_TX_MCLR)),
        .wdata(bus_wdata[NUM_CH-1:0]),
        .raw(tx_raw), .mask(tx_mask), .masked(tx_masked)
    );

    chdma_irq_grp #(.W(NUM_CH)) u_rx_grp (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .set_evt(rx_done_evt), .ack(rx_cp_ack),
        .mset_we(wr_ok && hit(bus_addr, OFS_RX_MSET)),
        .mclr_we(wr_ok && hit(bus_addr, OFS_RX_MCLR)),
        .wdata(bus_wdata[NUM_CH-1:0]),
        .raw(rx_raw), .mask(rx_mask), .masked(rx_masked)
    );

    chdma_irq_grp #(.W(DMA_GRP_W), .WR_MASK(DMA_WR_MASK)) u_dma_grp (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .set_evt({host_err_evt, 1'b0}), .ack('0),
        .mset_we(wr_ok && hit(bus_addr, OFS_DMA_MSET)),
        .mclr_we(wr_ok && hit(bus_addr, OFS_DMA_MCLR)),
        .wdata(bus_wdata[DMA_GRP_W-1:0]),
        .raw(dma_raw), .mask(dma_mask), .masked(dma_masked)
    );

    assign any_masked = (|tx_masked) || (|rx_masked) || (|dma_masked);

    chdma_ctl_fsm #(.RESET_CYCLES(RESET_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sr_req(sr_we), .eoi_req(eoi_we), .any_masked(any_masked),
        .busy(sr_busy), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_enable <= 1'b0;
            rx_enable <= 1'b0;
            td_tx_req <= 1'b0;
            td_rx_req <= 1'b0;
            td_chan   <= '0;
        end else begin
            td_tx_req <= wr_ok && hit(bus_addr, OFS_TX_TD);
            td_rx_req <= wr_ok && hit(bus_addr, OFS_RX_TD);
            if (wr_ok && (hit(bus_addr, OFS_TX_TD) || hit(bus_addr, OFS_RX_TD)))
                td_chan <= bus_wdata[CHW-1:0];
            if (clr) begin
                tx_enable <= 1'b0;
                rx_enable <= 1'b0;
            end else begin
                if (wr_ok && hit(bus_addr, OFS_TX_CTL)) tx_enable <= bus_wdata[0];
                if (wr_ok && hit(bus_addr, OFS_RX_CTL)) rx_enable <= bus_wdata[0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFS_TX_CTL))       bus_rdata[0] = tx_enable;
        else if (hit(bus_addr, OFS_RX_CTL))  bus_rdata[0] = rx_enable;
        else if (hit(bus_addr, OFS_SRST))    bus_rdata[0] = sr_busy;
        else if (hit(bus_addr, OFS_TX_RAW))  bus_rdata[NUM_CH-1:0] = tx_raw;
        else if (hit(bus_addr, OFS_TX_MSKD)) bus_rdata[NUM_CH-1:0] = tx_masked;
        else if (hit(bus_addr, OFS_TX_MSET) || hit(bus_addr, OFS_TX_MCLR))
            bus_rdata[NUM_CH-1:0] = tx_mask;
        else if (hit(bus_addr, OFS_RX_RAW))  bus_rdata[NUM_CH-1:0] = rx_raw;
        else if (hit(bus_addr, OFS_RX_MSKD)) bus_rdata[NUM_CH-1:0] = rx_masked;
        else if (hit(bus_addr, OFS_RX_MSET) || hit(bus_addr, OFS_RX_MCLR))
            bus_rdata[NUM_CH-1:0] = rx_mask;
        else if (hit(bus_addr, OFS_DMA_RAW))  bus_rdata[DMA_GRP_W-1:0] = dma_raw;
        else if (hit(bus_addr, OFS_DMA_MSKD)) bus_rdata[DMA_GRP_W-1:0] = dma_masked;
        else if (hit(bus_addr, OFS_DMA_MSET) || hit(bus_addr, OFS_DMA_MCLR))
            bus_rdata[DMA_GRP_W-1:0] = dma_mask;
    end
endmodule

// File: rtl/chdma_csr_sva.sv
module chdma_csr_sva
    import chdma_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int AW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              busy,
    input logic              any_masked,
    input logic              irq,
    input logic [NUM_CH-1:0] tx_done_evt,
    input logic [NUM_CH-1:0] tx_raw,
    input logic [NUM_CH-1:0] tx_mask,
    input logic              tx_enable,
    input logic              td_tx_req
);
    logic eoi_w, sr_w, txtd_w;
    assign eoi_w  = bus_we && !busy && bus_addr == AW'(OFS_EOI);
    assign sr_w   = bus_we && !busy && bus_addr == AW'(OFS_SRST) && bus_wdata[0];
    assign txtd_w = bus_we && !busy && bus_addr == AW'(OFS_TX_TD);

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(any_masked));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi_w && !sr_w) |=> irq);

    p_eoi_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_w |=> !irq);

    p_raw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sr_w) |=> ((tx_raw & $past(tx_done_evt)) == $past(tx_done_evt)));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tx_mask == '0 && !tx_enable && !irq));

    p_td_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txtd_w |=> td_tx_req);
endmodule

bind chdma_csr_top chdma_csr_sva #(.NUM_CH(NUM_CH), .AW(AW)) u_sva (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .busy(sr_busy), .any_masked(any_masked), .irq(irq),
    .tx_done_evt(tx_done_evt), .tx_raw(tx_raw), .tx_mask(tx_mask),
    .tx_enable(tx_enable), .td_tx_req(td_tx_req)
);

// File: tb/chdma_csr_top_test.sv
module chdma_csr_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 8;
    localparam int AW = 8;
    localparam int CHW = 3;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NUM_CH-1:0] tx_done_evt = '0, rx_done_evt = '0, tx_cp_ack = '0, rx_cp_ack = '0;
    logic host_err_evt = 0;
    logic tx_enable, rx_enable, td_tx_req, td_rx_req, irq;
    logic [CHW-1:0] td_chan;

    int n_chk = 0, n_fail = 0;

    chdma_csr_top #(.NUM_CH(NUM_CH), .AW(AW), .RESET_CYCLES(8)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        rd;
        logic [7:0]  a;
        logic [31:0] d;
        logic [3:0]  req;
    } vec_t;
    localparam int NV = 16;
    // Enable registers (R2) and mask set/clear behaviour (R6)
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h04, 32'h1,        4'd2},
        '{1'b1, 8'h04, 32'h1,        4'd2},
        '{1'b0, 8'h14, 32'h1,        4'd2},
        '{1'b1, 8'h14, 32'h1,        4'd2},
        '{1'b0, 8'h88, 32'h0F,       4'd6},
        '{1'b1, 8'h88, 32'h0F,       4'd6},
        '{1'b0, 8'h8C, 32'h05,       4'd6},
        '{1'b1, 8'h8C, 32'h0A,       4'd6},
        '{1'b0, 8'hA8, 32'hF0,       4'd6},
        '{1'b1, 8'hAC, 32'hF0,       4'd6},
        '{1'b0, 8'hB8, 32'hFFFFFFFF, 4'd6},
        '{1'b1, 8'hB8, 32'h2,        4'd6},
        '{1'b0, 8'h04, 32'h0,        4'd2},
        '{1'b1, 8'h04, 32'h0,        4'd2},
        '{1'b0, 8'h88, 32'h0,        4'd6},
        '{1'b1, 8'h88, 32'h0A,       4'd6}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] txe, input logic [NUM_CH-1:0] rxe,
                         input logic he, input logic [NUM_CH-1:0] txa);
        @(negedge clk);
        tx_done_evt = txe; rx_done_evt = rxe; host_err_evt = he; tx_cp_ack = txa;
        @(negedge clk);
        tx_done_evt = '0; rx_done_evt = '0; host_err_evt = 0; tx_cp_ack = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int busy_cnt;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        #1 chk("R1 irq", irq, 0);
        chk("R1 enables", {tx_enable, rx_enable, td_tx_req, td_rx_req}, 0);
        rd_chk(8'h04, 0, "R1 txctl");
        rd_chk(8'h1C, 0, "R1 srst");
        rd_chk(8'h80, 0, "R1 txraw");
        rd_chk(8'hA8, 0, "R1 rxmask");
        rd_chk(8'hB0, 0, "R1 dmaraw");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) rd_chk(VEC[i].a, VEC[i].d, $sformatf("R%0d table %0d", VEC[i].req, i));
            else           wr(VEC[i].a, VEC[i].d);
        end
        #1 chk("R2 rx_enable pin", rx_enable, 1);
        chk("R2 tx_enable pin", tx_enable, 0);

        // R4 / R7: events on unmasked bits
        pulse(8'h05, '0, 0, '0);
        #1 chk("R8 no irq for unmasked", irq, 0);
        rd_chk(8'h80, 32'h05, "R4 txraw");
        rd_chk(8'h84, 32'h00, "R7 txmasked zero");
        #1 chk("R8 still low", irq, 0);

        // R8: masked event, irq one cycle later
        pulse(8'h02, '0, 0, '0);
        #1 chk("R8 irq not yet", irq, 0);
        @(negedge clk); #1 chk("R8 irq rises", irq, 1);
        rd_chk(8'h84, 32'h02, "R7 txmasked");

        // R5: ack clears, irq holds
        pulse('0, '0, 0, 8'h02);
        rd_chk(8'h80, 32'h05, "R5 ack clears");
        #1 chk("R8 hold", irq, 1);

        // R9: EOI with nothing pending
        wr(8'h94, 0);
        #1 chk("R9 drop", irq, 0);
        @(negedge clk); #1 chk("R9 stays low", irq, 0);

        // R4 host error, R9 reassert
        pulse('0, '0, 1, '0);
        rd_chk(8'hB0, 32'h2, "R4 hosterr raw");
        rd_chk(8'hB4, 32'h2, "R7 dma masked");
        #1 chk("R8 host irq", irq, 1);
        wr(8'h94, 0);
        #1 chk("R9 gap", irq, 0);
        @(negedge clk); #1 chk("R9 reassert", irq, 1);

        // R5 same-cycle event and ack
        pulse(8'h01, '0, 0, 8'h01);
        rd_chk(8'h80, 32'h05, "R5 event wins");
        pulse('0, '0, 0, 8'h04);
        rd_chk(8'h80, 32'h01, "R5 ack bit2");

        // R4 receive
        pulse('0, 8'h81, 0, '0);
        rd_chk(8'hA0, 32'h81, "R4 rxraw");
        rd_chk(8'hA4, 32'h80, "R7 rxmasked");

        // R3 teardown pulses
        wr(8'h08, 32'h5);
        #1 chk("R3 tx td", {td_tx_req, td_rx_req, 1'b0, td_chan}, {2'b10, 1'b0, 3'd5});
        @(negedge clk); #1 chk("R3 tx td one cycle", td_tx_req, 0);
        wr(8'h18, 32'h3);
        #1 chk("R3 rx td", {td_tx_req, td_rx_req, 1'b0, td_chan}, {2'b01, 1'b0, 3'd3});
        @(negedge clk); #1 chk("R3 rx td one cycle", td_rx_req, 0);

        // R10 writing 0 has no effect
        wr(8'h1C, 0);
        rd_chk(8'h1C, 0, "R10 zero write");
        rd_chk(8'h88, 32'h0A, "R10 zero write keeps mask");

        // R10 soft reset length and clearing
        wr(8'h1C, 1);
        bus_addr = 8'h1C;
        #1 chk("R10 irq cleared", irq, 0);
        busy_cnt = 0;
        for (int k = 0; k < 20; k++) begin
            if (bus_rdata[0] !== 1'b1) break;
            busy_cnt++;
            @(negedge clk); #1;
        end
        chk("R10 reset length", busy_cnt, 8);
        rd_chk(8'h88, 0, "R10 mask cleared");
        rd_chk(8'h80, 0, "R10 raw cleared");
        rd_chk(8'hB0, 0, "R10 dma raw cleared");
        rd_chk(8'h14, 0, "R10 enable cleared");

        // R10 activity during reset is ignored
        wr(8'h1C, 1);
        wr(8'h88, 32'hFF);
        pulse(8'hFF, 8'hFF, 1, '0);
        repeat (10) @(negedge clk);
        rd_chk(8'h88, 0, "R10 write ignored");
        rd_chk(8'h80, 0, "R10 event ignored");
        rd_chk(8'hA0, 0, "R10 rx event ignored");
        #1 chk("R10 irq after", irq, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule